// File: doc/BRIEF.md
# Half-Bridge Output Controller with Hold-Current PWM

This block turns per-channel on-commands for a bank of half-bridge outputs into gate enables for each channel's upper (high-side) and lower (low-side) switch. Commands come straight from control register bits. Fault flags arrive already filtered and latched. They are an overload flag per channel, a thermal shutdown flag, and an undervoltage flag for each of the two supply groups. Group A feeds channels 1 to 4 and group B feeds channels 5 to 8. While a fault flag is raised, the affected outputs are forced off.

Any channel can run in a hold-current mode. In that mode a shared low-frequency PWM waveform, nominally 100 Hz, gates whichever switch that channel commands. A 2-bit code selects the duty cycle. During the PWM low phase the channel floats in tri-state.

Two rules prevent shoot-through:
- A command that asks for both switches of one channel yields neither.
- A switch may not turn on until a fixed dead time has passed since the opposite switch of the same channel turned off.

Top module: `hb_out_ctrl`

## Requirements
- R1: While reset is active, and one cycle after `standby` is sampled high, every channel is tri-state (`hi_on` = 0, `lo_on` = 0, `tri_st` all ones).
- R2: With no fault, no hold mode and no pending dead time, a channel whose bit is set in exactly one of `hi_cmd` or `lo_cmd` drives that switch on from the first clock edge that samples the command. Clearing the command turns the switch off at the next edge. Bit i of every per-channel vector belongs to channel i+1.
- R3: A channel whose bit is set in both `hi_cmd` and `lo_cmd` keeps both switches off and reports tri-state. Other channels are unaffected.
- R4: The two switches of a channel are never on together. When a channel changes side, the new switch turns on exactly `DEAD_CYC` cycles after the previous switch turned off.
- R5: A set `ovl_flag` bit forces only its own channel off from the next edge. The channel resumes once the bit clears.
- R6: `tsd_flag` forces all channels off from the next edge. They resume when it clears.
- R7: `uv_grp_a` or `uv_grp_b` forces all eight channels off for as long as either flag stays set.
- R8: The hold PWM period is `CLK_HZ/PWM_HZ` cycles. Over one period, a hold-mode switch is on for floor(period × 15 × (code+1) / 100) cycles, where `hold_duty` code 0, 1, 2, 3 selects 15, 30, 45, 60 %. This applies to the high side and the low side alike.
- R9: Hold mode applies only to channels whose `hold_mask` bit is set. Such a channel is tri-state during the PWM low phase. Unmasked channels stay on continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Forces all channels tri-state and holds the PWM counter |
| hi_cmd | input | NCH | High-side on-command per channel |
| lo_cmd | input | NCH | Low-side on-command per channel |
| hold_mask | input | NCH | Enables hold-current PWM per channel |
| hold_duty | input | 2 | Hold PWM duty code |
| ovl_flag | input | NCH | Latched overload flag per channel |
| tsd_flag | input | 1 | Latched thermal shutdown flag |
| uv_grp_a | input | 1 | Latched undervoltage flag, supply group A |
| uv_grp_b | input | 1 | Latched undervoltage flag, supply group B |
| hi_on | output | NCH | High-side gate enable per channel |
| lo_on | output | NCH | Low-side gate enable per channel |
| tri_st | output | NCH | Channel has both switches off |

## Verification
Mixed command words set high-side and low-side channels in one cycle. This shows that each bit lands on its own channel and switch. A conflicting command on one channel next to a single-sided command on another separates per-channel conflict handling from any global effect. Side swaps are sampled one cycle before and exactly at the dead-time boundary, in both directions, to pin the delay to the cycle. Each duty code is measured by counting on-cycles over one full period. That count does not depend on phase alignment, and running it on the low side as well as the high side shows that the gating does not depend on which switch is commanded.

// File: rtl/hb_out_pkg.sv
package hb_out_pkg;

  localparam int HOLD_STEP_PCT = 15;

  // on-cycles per PWM period for a 2-bit duty code (15/30/45/60 %)
  function automatic int hold_on_cycles(input int period, input logic [1:0] code);
    return (period * HOLD_STEP_PCT * (int'(code) + 1)) / 100;
  endfunction

  typedef enum logic {SIDE_HI = 1'b0, SIDE_LO = 1'b1} side_e;

endpackage

// File: rtl/hb_pwm_gen.sv
module hb_pwm_gen #(
  parameter int PERIOD = 2500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic [1:0] duty,
  output logic       phase_on
);
  import hb_out_pkg::*;

  localparam int CW = $clog2(PERIOD);

  logic [CW-1:0] pcnt;
  logic [31:0]   on_lim;

  assign on_lim   = 32'(hold_on_cycles(PERIOD, duty));
  assign phase_on = (32'(pcnt) < on_lim);

  always_ff @(posedge clk) begin
    if (!rst_n || hold)                  pcnt <= '0;
    else if (pcnt == CW'(PERIOD - 1))    pcnt <= '0;
    else                                 pcnt <= pcnt + 1'b1;
  end

  // R8
  pwm_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pcnt == '0) |-> phase_on);

endmodule

// File: rtl/hb_half_bridge.sv
module hb_half_bridge #(
  parameter int DEAD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want_hi,
  input  logic want_lo,
  input  logic kill,
  input  logic gate,
  output logic hi_on,
  output logic lo_on
);
  import hb_out_pkg::*;

  localparam int CW = $clog2(DEAD + 1);
  localparam int GW = $clog2(DEAD + 2);

  logic [CW-1:0] dcnt;
  side_e         last;
  logic          req_hi, req_lo, hi_nxt, lo_nxt, hi_fall, lo_fall, dead_ok_hi, dead_ok_lo;

  assign req_hi     = want_hi & ~want_lo & ~kill & gate;
  assign req_lo     = want_lo & ~want_hi & ~kill & gate;
  assign dead_ok_hi = (dcnt == '0) || (last == SIDE_HI);
  assign dead_ok_lo = (dcnt == '0) || (last == SIDE_LO);
  assign hi_nxt     = req_hi & ~lo_on & dead_ok_hi;
  assign lo_nxt     = req_lo & ~hi_on & dead_ok_lo;
  assign hi_fall    = hi_on & ~hi_nxt;
  assign lo_fall    = lo_on & ~lo_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_on <= 1'b0;
      lo_on <= 1'b0;
      dcnt  <= '0;
      last  <= SIDE_HI;
    end else begin
      hi_on <= hi_nxt;
      lo_on <= lo_nxt;
      if (hi_fall) begin
        dcnt <= CW'(DEAD - 1);
        last <= SIDE_HI;
      end else if (lo_fall) begin
        dcnt <= CW'(DEAD - 1);
        last <= SIDE_LO;
      end else if (dcnt != '0) begin
        dcnt <= dcnt - 1'b1;
      end
    end
  end

  // checker: cycles since each switch was last on, saturating
  logic [GW-1:0] gap_hi, gap_lo;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_hi <= GW'(DEAD);
      gap_lo <= GW'(DEAD);
    end else begin
      if (hi_on) gap_hi <= '0;
      else if (gap_hi != GW'(DEAD)) gap_hi <= gap_hi + 1'b1;
      if (lo_on) gap_lo <= '0;
      else if (gap_lo != GW'(DEAD)) gap_lo <= gap_lo + 1'b1;
    end
  end

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_on && lo_on));
  // R4
  dead_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_on) |-> (gap_hi >= GW'(DEAD)));
  // R4
  dead_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_on) |-> (gap_lo >= GW'(DEAD)));
  // R3
  both_cmd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (want_hi && want_lo) |=> (!hi_on && !lo_on));
  // R5
  kill_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!hi_on && !lo_on));
  // R9
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> (!hi_on && !lo_on));

endmodule

// File: rtl/hb_out_ctrl.sv
module hb_out_ctrl #(
  parameter int NCH      = 8,
  parameter int CLK_HZ   = 250000000,
  parameter int PWM_HZ   = 100,
  parameter int DEAD_CYC = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           standby,
  input  logic [NCH-1:0] hi_cmd,
  input  logic [NCH-1:0] lo_cmd,
  input  logic [NCH-1:0] hold_mask,
  input  logic [1:0]     hold_duty,
  input  logic [NCH-1:0] ovl_flag,
  input  logic           tsd_flag,
  input  logic           uv_grp_a,
  input  logic           uv_grp_b,
  output logic [NCH-1:0] hi_on,
  output logic [NCH-1:0] lo_on,
  output logic [NCH-1:0] tri_st
);

  localparam int PERIOD = CLK_HZ / PWM_HZ;

  logic phase_on;
  logic global_kill;

  assign global_kill = standby | tsd_flag | uv_grp_a | uv_grp_b;

  hb_pwm_gen #(.PERIOD(PERIOD)) u_pwm (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (standby),
    .duty     (hold_duty),
    .phase_on (phase_on)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic ch_kill, ch_gate;
    assign ch_kill = global_kill | ovl_flag[i];
    assign ch_gate = ~hold_mask[i] | phase_on;

    hb_half_bridge #(.DEAD(DEAD_CYC)) u_hb (
      .clk     (clk),
      .rst_n   (rst_n),
      .want_hi (hi_cmd[i]),
      .want_lo (lo_cmd[i]),
      .kill    (ch_kill),
      .gate    (ch_gate),
      .hi_on   (hi_on[i]),
      .lo_on   (lo_on[i])
    );

    // R5
    ovl_own_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_flag[i] |=> (!hi_on[i] && !lo_on[i]));
  end

  assign tri_st = ~(hi_on | lo_on);

  // R1
  standby_tri_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (tri_st == '1));
  // R6
  tsd_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_flag |=> (hi_on == '0 && lo_on == '0));
  // R7
  uv_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_grp_a || uv_grp_b) |=> (hi_on == '0 && lo_on == '0));

endmodule

// File: tb/hb_out_ctrl_tb.sv
`timescale 1ns/1ps
module hb_out_ctrl_tb;

  localparam int NCH    = 8;
  localparam int DEAD   = 16;
  localparam int CLK_HZ = 20000;
  localparam int PWM_HZ = 100;
  localparam int PER    = CLK_HZ / PWM_HZ;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           standby = 1'b0;
  logic [NCH-1:0] hi_cmd = '0, lo_cmd = '0, hold_mask = '0, ovl_flag = '0;
  logic [1:0]     hold_duty = 2'd0;
  logic           tsd_flag = 1'b0, uv_grp_a = 1'b0, uv_grp_b = 1'b0;
  logic [NCH-1:0] hi_on, lo_on, tri_st;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hb_out_ctrl #(.NCH(NCH), .CLK_HZ(CLK_HZ), .PWM_HZ(PWM_HZ), .DEAD_CYC(DEAD)) u_dut (
    .clk(clk), .rst_n(rst_n), .standby(standby),
    .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .hold_mask(hold_mask), .hold_duty(hold_duty),
    .ovl_flag(ovl_flag), .tsd_flag(tsd_flag), .uv_grp_a(uv_grp_a), .uv_grp_b(uv_grp_b),
    .hi_on(hi_on), .lo_on(lo_on), .tri_st(tri_st)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [NCH-1:0] h, input logic [NCH-1:0] l);
    @(negedge clk);
    hi_cmd = h;
    lo_cmd = l;
  endtask

  task automatic t_reset;
    step(3);
    chk(tri_st == 8'hFF, "R1 reset tri", int'(tri_st), 'hFF);
    chk((hi_on | lo_on) == 8'h00, "R1 reset off", int'(hi_on | lo_on), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_direct;
    drive(8'h0F, 8'hF0);
    step(1);
    chk(hi_on == 8'h0F, "R2 hi immediate", int'(hi_on), 'h0F);
    chk(lo_on == 8'hF0, "R2 lo immediate", int'(lo_on), 'hF0);
    chk(tri_st == 8'h00, "R2 tri clear", int'(tri_st), 0);
    drive(8'h00, 8'h00);
    step(1);
    chk(tri_st == 8'hFF, "R2 off next edge", int'(tri_st), 'hFF);
    step(DEAD + 2);
  endtask

  task automatic t_both;
    drive(8'h81, 8'h01);
    step(DEAD + 2);
    chk(hi_on == 8'h80, "R3 conflict ch1 off, ch8 on", int'(hi_on), 'h80);
    chk(lo_on == 8'h00, "R3 conflict lo off", int'(lo_on), 0);
    chk(tri_st[0] == 1'b1, "R3 conflict tri", int'(tri_st[0]), 1);
    drive(8'h00, 8'h00);
    step(DEAD + 2);
  endtask

  task automatic t_dead;
    drive(8'h04, 8'h00);
    step(DEAD + 2);
    chk(hi_on == 8'h04, "R4 setup hi", int'(hi_on), 'h04);
    drive(8'h00, 8'h04);
    step(1);
    chk(hi_on[2] == 1'b0 && lo_on[2] == 1'b0, "R4 hi off first", int'({hi_on[2], lo_on[2]}), 0);
    step(DEAD - 1);
    chk(lo_on[2] == 1'b0, "R4 lo held in dead time", int'(lo_on[2]), 0);
    step(1);
    chk(lo_on[2] == 1'b1, "R4 lo on at dead boundary", int'(lo_on[2]), 1);
    drive(8'h04, 8'h00);
    step(1);
    chk(lo_on[2] == 1'b0 && hi_on[2] == 1'b0, "R4 lo off first", int'({hi_on[2], lo_on[2]}), 0);
    step(DEAD - 1);
    chk(hi_on[2] == 1'b0, "R4 hi held in dead time", int'(hi_on[2]), 0);
    step(1);
    chk(hi_on[2] == 1'b1, "R4 hi on at dead boundary", int'(hi_on[2]), 1);
  endtask

  task automatic t_ovl;
    drive(8'hFF, 8'h00);
    step(DEAD + 2);
    chk(hi_on == 8'hFF, "R5 setup all hi", int'(hi_on), 'hFF);
    @(negedge clk) ovl_flag = 8'h04;
    step(1);
    chk(hi_on == 8'hFB, "R5 only ch3 off", int'(hi_on), 'hFB);
    chk(tri_st == 8'h04, "R5 only ch3 tri", int'(tri_st), 'h04);
    @(negedge clk) ovl_flag = 8'h00;
    step(1);
    chk(hi_on == 8'hFF, "R5 resume", int'(hi_on), 'hFF);
  endtask

  task automatic t_tsd;
    @(negedge clk) tsd_flag = 1'b1;
    step(1);
    chk(tri_st == 8'hFF, "R6 thermal all off", int'(tri_st), 'hFF);
    @(negedge clk) tsd_flag = 1'b0;
    step(1);
    chk(hi_on == 8'hFF, "R6 resume", int'(hi_on), 'hFF);
  endtask

  task automatic t_uv;
    @(negedge clk) uv_grp_a = 1'b1;
    step(1);
    chk(tri_st == 8'hFF, "R7 group A uv all off", int'(tri_st), 'hFF);
    @(negedge clk) uv_grp_a = 1'b0;
    step(1);
    chk(hi_on == 8'hFF, "R7 resume after A", int'(hi_on), 'hFF);
    @(negedge clk) uv_grp_b = 1'b1;
    step(6);
    chk(tri_st == 8'hFF, "R7 group B uv held off", int'(tri_st), 'hFF);
    @(negedge clk) uv_grp_b = 1'b0;
    step(1);
    chk(hi_on == 8'hFF, "R7 resume after B", int'(hi_on), 'hFF);
  endtask

  task automatic measure(input int ch, input bit lo_side, output int on_cnt, output int tri_err, output int other_err);
    on_cnt = 0; tri_err = 0; other_err = 0;
    for (int k = 0; k < PER; k++) begin
      step(1);
      if (lo_side ? lo_on[ch] : hi_on[ch]) on_cnt++;
      else if (!tri_st[ch]) tri_err++;
      if (!lo_side && hi_on[7:1] != 7'h7F) other_err++;
    end
  endtask

  task automatic t_pwm;
    int on_cnt, tri_err, other_err, exp;
    @(negedge clk) hold_mask = 8'h01;
    for (int d = 0; d < 4; d++) begin
      @(negedge clk) hold_duty = 2'(d);
      step(PER + 2);
      measure(0, 1'b0, on_cnt, tri_err, other_err);
      exp = PER * (d + 1) * 3 / 20;
      chk(on_cnt == exp, "R8 hi duty on-count", on_cnt, exp);
      chk(tri_err == 0, "R9 tri in low phase", tri_err, 0);
      chk(other_err == 0, "R9 unmasked channels steady", other_err, 0);
    end
    drive(8'h00, 8'h08);
    @(negedge clk) begin hold_mask = 8'h08; hold_duty = 2'd3; end
    step(PER + DEAD + 2);
    measure(3, 1'b1, on_cnt, tri_err, other_err);
    chk(on_cnt == PER * 4 * 3 / 20, "R8 lo duty on-count", on_cnt, PER * 4 * 3 / 20);
    chk(tri_err == 0, "R9 lo tri in low phase", tri_err, 0);
    @(negedge clk) hold_mask = 8'h00;
    step(2);
    measure(3, 1'b1, on_cnt, tri_err, other_err);
    chk(on_cnt == PER, "R9 mask cleared full on", on_cnt, PER);
  endtask

  task automatic t_standby;
    @(negedge clk) standby = 1'b1;
    step(1);
    chk(tri_st == 8'hFF, "R1 standby tri", int'(tri_st), 'hFF);
    @(negedge clk) standby = 1'b0;
    step(1);
    chk(lo_on == 8'h08, "R1 standby release", int'(lo_on), 'h08);
  endtask

  initial begin
    t_reset();
    t_direct();
    t_both();
    t_dead();
    t_ovl();
    t_tsd();
    t_uv();
    t_pwm();
    t_standby();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule